// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank SDR SDRAM from reset onwards. It first holds the bus at NOP for a startup pause, whose length is derived from a time parameter and the clock period. It then precharges every bank and runs a fixed burst of eight auto-refresh commands. A mode register set, carrying a configurable mode word on the address bus, closes the sequence. A done flag rises once the mode-set settling time has passed.

After initialization a pacing counter raises one refresh request per interval. The interval is chosen so that every row is refreshed within the retention period. Requests are served as soon as the command bus is free. The bus is handed to a user access port through a request/grant handshake. While the port holds the grant, refresh requests pile up in a saturating backlog. After the port reports idle and the write-recovery time has passed, the backlog is issued back to back.

A self-refresh request parks the memory with CKE low. On exit the sequencer respects the exit delay and forces a two-refresh recovery burst before the port can be granted again.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is held, the command {cs_n,ras_n,cas_n,we_n} is NOP (4'b0111), cke is 1, sd_addr is 0, and init_done, ref_busy and acc_gnt are 0.
- R2: After reset release only NOP appears for PAUSE_CYC = ceil(STARTUP_US*1e6 / CLK_PERIOD_PS) cycles. The first command is precharge-all (4'b0010) with sd_addr bit 10 set, and it appears PAUSE_CYC cycles after reset release.
- R3: The first of exactly eight auto-refresh commands (4'b0001) follows the precharge-all after TRP_CYC cycles. A mode register set (4'b0000) follows the eighth, with MODE_WORD (default 13'h032) on sd_addr.
- R4: The next command after any auto-refresh comes no sooner than TRC_CYC cycles later. During initialization the spacing is exactly TRC_CYC.
- R5: init_done rises exactly TMRD_CYC cycles after the mode register set and then stays high.
- R6: Refresh interval REFI = floor(floor(RETENTION_MS*1e6 / ROW_COUNT) * 1000 / CLK_PERIOD_PS) cycles; one refresh is owed per interval. With an idle bus, the first periodic auto-refresh appears REFI+1 cycles after init_done rises, and later ones follow every REFI cycles.
- R7: acc_gnt rises the cycle after acc_req is seen with nothing owed, and no command is issued while it is high. It falls the cycle after acc_idle is seen. Intervals that elapse meanwhile are owed up to a limit of MAX_PENDING (8) and are then issued at a spacing of TRC_CYC+1.
- R8: The first command after acc_gnt falls appears exactly TWR_CYC+1 cycles after the fall.
- R9: Self-refresh entry is an auto-refresh with cke low. cke then stays low for at least SR_MIN_CYC cycles and as long as sr_req is high, with only NOP on the bus. cke rises the cycle after sr_req is seen low.
- R10: After cke rises, only NOP is issued for TSREX_CYC+1 cycles. Two auto-refreshes then follow, the first at TSREX_CYC+2 cycles after the rise, before any grant.
- R11: Owed refreshes win over self-refresh entry, and both win over a grant. ref_busy is high on every maintenance auto-refresh issued with cke high, and for its TRC_CYC window. It is never high together with acc_gnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Request to enter and stay in self-refresh |
| acc_req | input | 1 | User port asks for the command bus |
| acc_idle | input | 1 | User port has finished; releases the grant |
| acc_gnt | output | 1 | Command bus granted to the user port |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| sd_addr | output | 13 | Address bus: bit 10 for precharge-all, mode word for mode set |
| init_done | output | 1 | Initialization finished |
| ref_busy | output | 1 | Maintenance refresh in progress |

## Verification
Two decisions can land on the same idle cycle: serving an owed refresh and granting the user port. Self-refresh is left in the same cycle that acc_req is raised, so the two-refresh recovery backlog and the access request meet on the first idle cycle after the exit delay. The bench expects both recovery refreshes at their exact cycles, and acc_gnt only TRC_CYC+1 cycles after the second. A grant held across ten refresh intervals separately confirms that the backlog saturates at eight and drains only after write recovery.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Command encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_PRE_WAIT,
        ST_INIT_WAIT,
        ST_MRD_WAIT,
        ST_IDLE,
        ST_GRANT,
        ST_WR_REC,
        ST_REF_WAIT,
        ST_SELF_REF,
        ST_SR_EXIT
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_refresh_pacer.sv
module sdram_refresh_pacer #(
    parameter int unsigned INTERVAL = 976
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int unsigned W = $clog2(INTERVAL + 1);
    localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            if (cnt_q == LAST) begin
                tick  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sdram_refresh_backlog.sv
module sdram_refresh_backlog #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned RELOAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    input  logic load,
    output logic owed
);
    localparam int unsigned W = $clog2(max_u_local(DEPTH, RELOAD) + 1);

    function automatic int unsigned max_u_local(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam logic [W-1:0] FULL   = W'(DEPTH);
    localparam logic [W-1:0] REFILL = W'(RELOAD);

    logic [W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (load) begin
            lvl_d = REFILL;
        end else if (add && !take) begin
            if (lvl_q != FULL) lvl_d = lvl_q + 1'b1;
        end else if (take && !add) begin
            if (lvl_q != '0) lvl_d = lvl_q - 1'b1;
        end
    end

    assign owed = (lvl_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
    import sdram_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS  = 8000,
    parameter int unsigned STARTUP_US     = 100,
    parameter int unsigned RETENTION_MS   = 64,
    parameter int unsigned ROW_COUNT      = 8192,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned RECOVERY_REFS  = 2,
    parameter int unsigned MAX_PENDING    = 8,
    parameter int unsigned TRP_CYC        = 3,
    parameter int unsigned TRC_CYC        = 8,
    parameter int unsigned TMRD_CYC       = 2,
    parameter int unsigned TWR_CYC        = 2,
    parameter int unsigned TSREX_CYC      = 1,
    parameter int unsigned SR_MIN_CYC     = 2,
    parameter int unsigned ADDR_W         = 13,
    parameter logic [ADDR_W-1:0] MODE_WORD = ADDR_W'('h032)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_req,
    input  logic              acc_req,
    input  logic              acc_idle,
    output logic              acc_gnt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              ref_busy
);
    // Derived timing
    localparam int unsigned PAUSE_CYC = (STARTUP_US * 1000000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned REFI_NS   = (RETENTION_MS * 1000000) / ROW_COUNT;
    localparam int unsigned REFI_CYC  = (REFI_NS * 1000) / CLK_PERIOD_PS;

    localparam int unsigned LONGEST = max_u(max_u(PAUSE_CYC, TRC_CYC),
                                            max_u(max_u(TRP_CYC, TMRD_CYC),
                                                  max_u(max_u(TWR_CYC, TSREX_CYC + 1), SR_MIN_CYC)));
    localparam int unsigned CNT_W = $clog2(LONGEST + 1);
    localparam int unsigned REF_W = $clog2(INIT_REFRESHES + 1);

    localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(PAUSE_CYC - 1);
    localparam logic [CNT_W-1:0] TRP_LAST   = CNT_W'(TRP_CYC - 1);
    localparam logic [CNT_W-1:0] TRC_LAST   = CNT_W'(TRC_CYC - 1);
    localparam logic [CNT_W-1:0] TMRD_LAST  = CNT_W'(TMRD_CYC - 1);
    localparam logic [CNT_W-1:0] TWR_LAST   = CNT_W'(TWR_CYC - 1);
    localparam logic [CNT_W-1:0] SR_LAST    = CNT_W'(SR_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(TSREX_CYC);
    localparam logic [REF_W-1:0] INIT_LAST  = REF_W'(INIT_REFRESHES);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  refs;
        sd_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic              cke;
        logic              done;
        logic              busy;
        logic              gnt;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic ref_tick;
    logic ref_owed;
    logic ref_take;
    logic ref_reload;
    logic timer_run;
    logic timer_clear;

    // Interval pacing stops while the memory refreshes itself
    assign timer_run   = seq_q.done && (seq_q.state != ST_SELF_REF) && (seq_q.state != ST_SR_EXIT);
    assign timer_clear = (seq_q.state == ST_SR_EXIT);

    sdram_refresh_pacer #(
        .INTERVAL (REFI_CYC)
    ) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .clear (timer_clear),
        .tick  (ref_tick)
    );

    sdram_refresh_backlog #(
        .DEPTH  (MAX_PENDING),
        .RELOAD (RECOVERY_REFS)
    ) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (ref_tick),
        .take  (ref_take),
        .load  (ref_reload),
        .owed  (ref_owed)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.addr = '0;
        ref_take   = 1'b0;
        ref_reload = 1'b0;

        unique case (seq_q.state)
            ST_PAUSE: begin
                if (seq_q.cnt == PAUSE_LAST) begin
                    seq_d.cmd   = CMD_PRE;
                    seq_d.addr  = ALL_BANKS;
                    seq_d.state = ST_PRE_WAIT;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_PRE_WAIT: begin
                if (seq_q.cnt == TRP_LAST) begin
                    seq_d.cmd   = CMD_REF;
                    seq_d.refs  = REF_W'(1);
                    seq_d.state = ST_INIT_WAIT;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_INIT_WAIT: begin
                if (seq_q.cnt == TRC_LAST) begin
                    seq_d.cnt = '0;
                    if (seq_q.refs == INIT_LAST) begin
                        seq_d.cmd   = CMD_MRS;
                        seq_d.addr  = MODE_WORD;
                        seq_d.state = ST_MRD_WAIT;
                    end else begin
                        seq_d.cmd  = CMD_REF;
                        seq_d.refs = seq_q.refs + 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_MRD_WAIT: begin
                if (seq_q.cnt == TMRD_LAST) begin
                    seq_d.done  = 1'b1;
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_IDLE: begin
                seq_d.cnt = '0;
                if (ref_owed) begin
                    seq_d.cmd   = CMD_REF;
                    seq_d.busy  = 1'b1;
                    seq_d.state = ST_REF_WAIT;
                    ref_take    = 1'b1;
                end else if (sr_req) begin
                    seq_d.cmd   = CMD_REF;
                    seq_d.cke   = 1'b0;
                    seq_d.state = ST_SELF_REF;
                end else if (acc_req) begin
                    seq_d.gnt   = 1'b1;
                    seq_d.state = ST_GRANT;
                end
            end

            ST_GRANT: begin
                if (acc_idle) begin
                    seq_d.gnt   = 1'b0;
                    seq_d.state = ST_WR_REC;
                    seq_d.cnt   = '0;
                end
            end

            ST_WR_REC: begin
                if (seq_q.cnt == TWR_LAST) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_REF_WAIT: begin
                if (seq_q.cnt == TRC_LAST) begin
                    seq_d.busy  = 1'b0;
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_SELF_REF: begin
                if (!sr_req && (seq_q.cnt >= SR_LAST)) begin
                    seq_d.cke   = 1'b1;
                    seq_d.state = ST_SR_EXIT;
                    seq_d.cnt   = '0;
                end else if (seq_q.cnt < SR_LAST) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_SR_EXIT: begin
                if (seq_q.cnt == EXIT_LAST) begin
                    ref_reload  = 1'b1;
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            default: begin
                seq_d.state = ST_PAUSE;
                seq_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_PAUSE;
            seq_q.cnt   <= '0;
            seq_q.refs  <= '0;
            seq_q.cmd   <= CMD_NOP;
            seq_q.addr  <= '0;
            seq_q.cke   <= 1'b1;
            seq_q.done  <= 1'b0;
            seq_q.busy  <= 1'b0;
            seq_q.gnt   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = seq_q.cmd;
    assign cke       = seq_q.cke;
    assign sd_addr   = seq_q.addr;
    assign init_done = seq_q.done;
    assign ref_busy  = seq_q.busy;
    assign acc_gnt   = seq_q.gnt;

endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker
    import sdram_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd,
    input logic       cke,
    input logic       a10,
    input logic       init_done,
    input logic       ref_busy,
    input logic       acc_gnt
);

    // R1
    cke_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> cke);

    // R2
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> a10);

    // R3
    mrs_only_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> !init_done);

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R7
    gnt_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (cmd == CMD_NOP));

    // R9
    sr_entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd == CMD_REF));

    // R9
    sr_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (cmd == CMD_NOP));

    // R10
    sr_exit_nop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd == CMD_NOP));

    // R10
    sr_exit_nop_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |=> (cmd == CMD_NOP));

    // R11
    busy_gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_busy && acc_gnt));

endmodule

bind sdram_init_refresh_seq sdram_seq_checker u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       ({cs_n, ras_n, cas_n, we_n}),
    .cke       (cke),
    .a10       (sd_addr[10]),
    .init_done (init_done),
    .ref_busy  (ref_busy),
    .acc_gnt   (acc_gnt)
);

// File: tb/test_sdram_init_refresh_seq.sv
module test_sdram_init_refresh_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CLK_PS = 8000;
    localparam int PAUSE = (100 * 1000000 + CLK_PS - 1) / CLK_PS;
    localparam int REFI  = ((64 * 1000000) / 8192) * 1000 / CLK_PS;
    localparam int TRP = 3, TRC = 8, TMRD = 2, TWR = 2, TSREX = 1;
    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;
    localparam logic [12:0] MODE = 13'h032;
    localparam logic [12:0] A10  = 13'h0400;
    localparam int DONE_AT = PAUSE + TRP + 8 * TRC + TMRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0, acc_req = 1'b0, acc_idle = 1'b0;
    logic acc_gnt, cs_n, ras_n, cas_n, we_n, cke, init_done, ref_busy;
    logic [12:0] sd_addr;

    always #4 clk = ~clk;

    sdram_init_refresh_seq i_sdram_init_refresh_seq (
        .clk (clk), .rst_n (rst_n), .sr_req (sr_req), .acc_req (acc_req),
        .acc_idle (acc_idle), .acc_gnt (acc_gnt), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .cke (cke), .sd_addr (sd_addr),
        .init_done (init_done), .ref_busy (ref_busy)
    );

    typedef struct {
        logic [3:0]  cmd;
        logic [12:0] addr;
        logic        cke;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   log_cyc[$];
    int   n_cmp = 0, n_bad = 0;
    int   cyc = 0;
    int   gnt_rise = -1, gnt_fall = -1, cke_rise = -1, cke_fall = -1, done_rise = -1;
    logic gnt_prev = 1'b0, cke_prev = 1'b1, done_prev = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [12:0] a, input logic k, input string req);
        exp_t e;
        e.cmd = c; e.addr = a; e.cke = k; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Monitor: pops expected commands and compares them as they appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [3:0] c;
            c = {cs_n, ras_n, cas_n, we_n};
            if (c != C_NOP) begin
                log_cyc.push_back(cyc);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected command", int'(c), int'(C_NOP));
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(c == e.cmd && sd_addr == e.addr && cke == e.cke, e.req,
                          "cmd/addr/cke", int'({c, sd_addr, cke}), int'({e.cmd, e.addr, e.cke}));
                end
                if (c == C_REF && cke && init_done)
                    check(ref_busy == 1'b1, "R11", "ref_busy on refresh", int'(ref_busy), 1);
            end
            if (acc_gnt && !gnt_prev) gnt_rise = cyc;
            if (!acc_gnt && gnt_prev) gnt_fall = cyc;
            if (cke && !cke_prev) cke_rise = cyc;
            if (!cke && cke_prev) cke_fall = cyc;
            if (init_done && !done_prev) done_rise = cyc;
            gnt_prev  = acc_gnt;
            cke_prev  = cke;
            done_prev = init_done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R1", "watchdog expired", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int d, rel, s, x;
        repeat (5) @(negedge clk);
        // R1 reset state
        check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", "cmd in reset", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        check(cke && sd_addr == 0, "R1", "cke/addr in reset", int'({cke, sd_addr}), int'({1'b1, 13'h0}));
        check(!init_done && !ref_busy && !acc_gnt, "R1", "flags in reset", int'({init_done, ref_busy, acc_gnt}), 0);

        push(C_PRE, A10, 1'b1, "R2");
        for (int k = 0; k < 8; k++) push(C_REF, 13'h0, 1'b1, "R3");
        push(C_MRS, MODE, 1'b1, "R3");
        push(C_REF, 13'h0, 1'b1, "R6");
        push(C_REF, 13'h0, 1'b1, "R6");
        rst_n = 1'b1;

        wait_cyc(DONE_AT + 5);
        check(log_cyc.size() == 10, "R3", "init command count", log_cyc.size(), 10);
        if (log_cyc.size() >= 10) begin
            check(log_cyc[0] == PAUSE, "R2", "precharge cycle", log_cyc[0], PAUSE);
            for (int k = 1; k <= 8; k++)
                check(log_cyc[k] == PAUSE + TRP + (k - 1) * TRC, "R4", "init refresh cycle",
                      log_cyc[k], PAUSE + TRP + (k - 1) * TRC);
            check(log_cyc[9] == log_cyc[8] + TRC, "R3", "mode set cycle", log_cyc[9], log_cyc[8] + TRC);
            check(done_rise == log_cyc[9] + TMRD, "R5", "init_done rise", done_rise, log_cyc[9] + TMRD);
        end
        d = DONE_AT;

        wait_cyc(d + 2 * REFI + 10);
        check(log_cyc.size() == 12, "R6", "periodic count", log_cyc.size(), 12);
        if (log_cyc.size() >= 12) begin
            check(log_cyc[10] == d + REFI + 1, "R6", "first periodic", log_cyc[10], d + REFI + 1);
            check(log_cyc[11] == d + 2 * REFI + 1, "R6", "second periodic", log_cyc[11], d + 2 * REFI + 1);
        end
        check(init_done == 1'b1, "R5", "init_done held", int'(init_done), 1);

        // Grant held across ten intervals: backlog saturates at eight
        wait_cyc(d + 2 * REFI + 40);
        acc_req = 1'b1;
        wait_cyc(d + 2 * REFI + 45);
        check(acc_gnt == 1'b1, "R7", "grant given", int'(acc_gnt), 1);
        check(gnt_rise == d + 2 * REFI + 41, "R7", "grant rise cycle", gnt_rise, d + 2 * REFI + 41);
        for (int k = 0; k < 8; k++) push(C_REF, 13'h0, 1'b1, "R7");
        rel = d + 12 * REFI + 20;
        wait_cyc(rel);
        acc_idle = 1'b1;
        acc_req  = 1'b0;
        wait_cyc(rel + 2);
        acc_idle = 1'b0;
        wait_cyc(rel + 100);
        check(gnt_fall == rel + 1, "R7", "grant fall cycle", gnt_fall, rel + 1);
        check(log_cyc.size() == 20, "R7", "saturated backlog count", log_cyc.size(), 20);
        if (log_cyc.size() >= 20) begin
            check(log_cyc[12] == gnt_fall + TWR + 1, "R8", "write recovery gap", log_cyc[12], gnt_fall + TWR + 1);
            for (int k = 13; k < 20; k++)
                check(log_cyc[k] - log_cyc[k - 1] == TRC + 1, "R7", "burst spacing",
                      log_cyc[k] - log_cyc[k - 1], TRC + 1);
        end
        check(ref_busy == 1'b0, "R11", "ref_busy after burst", int'(ref_busy), 0);

        push(C_REF, 13'h0, 1'b1, "R6");
        wait_cyc(d + 13 * REFI + 20);
        if (log_cyc.size() >= 21)
            check(log_cyc[20] == d + 13 * REFI + 1, "R6", "pacing after grant", log_cyc[20], d + 13 * REFI + 1);
        else
            check(1'b0, "R6", "pacing after grant missing", log_cyc.size(), 21);

        // Self-refresh, then exit together with an access request
        s = d + 13 * REFI + 60;
        push(C_REF, 13'h0, 1'b0, "R9");
        push(C_REF, 13'h0, 1'b1, "R10");
        push(C_REF, 13'h0, 1'b1, "R10");
        wait_cyc(s);
        sr_req = 1'b1;
        x = s + 3000;
        wait_cyc(s + 10);
        check(cke == 1'b0, "R9", "cke low in self-refresh", int'(cke), 0);
        check(cke_fall == s + 1, "R9", "cke fall cycle", cke_fall, s + 1);
        wait_cyc(x);
        check(cke == 1'b0, "R9", "cke held while requested", int'(cke), 0);
        sr_req  = 1'b0;
        acc_req = 1'b1;
        wait_cyc(x + 60);
        check(cke_rise == x + 1, "R9", "cke rise cycle", cke_rise, x + 1);
        if (log_cyc.size() >= 24) begin
            check(log_cyc[21] == s + 1, "R9", "entry cycle", log_cyc[21], s + 1);
            check(log_cyc[22] == cke_rise + TSREX + 2, "R10", "first recovery refresh",
                  log_cyc[22], cke_rise + TSREX + 2);
            check(log_cyc[23] == log_cyc[22] + TRC + 1, "R10", "second recovery refresh",
                  log_cyc[23], log_cyc[22] + TRC + 1);
            check(gnt_rise == log_cyc[23] + TRC + 1, "R11", "grant after recovery",
                  gnt_rise, log_cyc[23] + TRC + 1);
        end else begin
            check(1'b0, "R10", "recovery refreshes missing", log_cyc.size(), 24);
        end
        acc_idle = 1'b1;
        acc_req  = 1'b0;
        wait_cyc(x + 64);
        acc_idle = 1'b0;
        wait_cyc(x + 80);
        check(sb_q.size() == 0, "R10", "expected commands left", sb_q.size(), 0);
        check(acc_gnt == 1'b0, "R7", "grant released", int'(acc_gnt), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule